// File: doc/BRIEF.md
# Eight-Output Addressable Latch

This block holds an eight-bit output word. Software or control logic changes that word one bit at a time. A three-bit selector names the bit, and a single data input supplies its new value. Two active-low controls choose what happens on each clock edge: a write strobe and a conditional clear.

When the clear is asserted with the strobe idle, the whole word goes to zero. When the clear and the strobe are both asserted, the block acts as a one-of-eight decoder: the selected bit takes the data value and every other bit goes to zero. With the clear idle and the strobe asserted, only the selected bit is rewritten and the others keep their values. With both controls idle the word is held.

All controls are sampled on the rising edge of the system clock, and the output register shows the result after that edge. A separate synchronous power-on reset, active high, zeroes the word.

Top module: `addr_latch8`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q` becomes 8'h00 after that edge, whatever the other inputs are.
- R2: With `clr_n`=0 and `we_n`=1 at an edge, `q` becomes 8'h00 whatever `sel` and `din` are.
- R3: With `clr_n`=0 and `we_n`=0 at an edge, `q` becomes `din << sel`: the bit at index `sel` equals `din` and the other seven bits are 0.
- R4: With `clr_n`=1 and `we_n`=1 at an edge, `q` keeps its value, and changes on `sel` and `din` have no effect.
- R5: With `clr_n`=1 and `we_n`=0 at an edge, bit `q[sel]` takes `din` and the other seven bits keep their values.
- R6: `sel` is binary, with `sel[0]` as its least significant bit. Value k selects `q[k]`; for example, 1 selects `q[1]` and 4 selects `q[4]`.
- R7: `q` changes only on a rising clock edge, one cycle after the inputs are sampled. After a series of write cycles, the held word equals the data of the last write to each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| clr_n | input | 1 | Conditional clear, active low |
| we_n | input | 1 | Write strobe, active low |
| sel | input | 3 | Bit selector, binary |
| din | input | 1 | Data bit to store |
| q | output | 8 | Registered output word |

## Verification
The hardest case to reach is the single-bit update. Its result depends on the word that earlier cycles left behind, so one cycle tested in isolation shows little. The stimulus therefore walks a chain of operations without clearing in between. It loads a varied pattern first, and then applies every combination of control pair, selector and data value. The result of each step is checked against a model word kept in the bench, so bits that are set survive and are then tested by the hold, update and decode steps. Hold cycles also wiggle the selector and data to show that neither input has any effect.

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             we_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic [N-1:0]     q
);

  logic [N-1:0] onehot;
  logic [N-1:0] q_nxt;

  assign onehot = N'(1) << sel;

  always_comb begin
    case ({clr_n, we_n})
      2'b01:   q_nxt = '0;
      2'b00:   q_nxt = din ? onehot : '0;
      2'b11:   q_nxt = q;
      default: q_nxt = (q & ~onehot) | (din ? onehot : '0);
    endcase
  end

  always_ff @(posedge clk)
    if (rst) q <= '0;
    else     q <= q_nxt;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == '0);
  a_r2_clear_all: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && we_n) |=> q == '0);
  a_r3_decode_others_low: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !we_n) |=> $countones(q) <= 1);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_n && we_n) |=> $stable(q));
  a_r5_update_bit: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !we_n) |=> q[$past(sel)] == $past(din));

endmodule

// File: tb/tb_addr_latch8.sv
module tb_addr_latch8;
  logic clk = 0;
  logic rst, clr_n, we_n, din;
  logic [2:0] sel;
  logic [7:0] q;
  logic [7:0] model;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_latch8 dut (.clk(clk), .rst(rst), .clr_n(clr_n), .we_n(we_n),
                   .sel(sel), .din(din), .q(q));

  task automatic check(input string req, input logic [7:0] exp);
    compared++;
    if (q !== exp) begin
      mismatched++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic [2:0] s, input logic d);
    clr_n = c; we_n = w; sel = s; din = d;
    @(posedge clk); #1;
    case ({c, w})
      2'b01: model = 8'h00;
      2'b00: model = d ? (8'h01 << s) : 8'h00;
      2'b11: model = model;
      default: begin model[s] = d; end
    endcase
  endtask

  initial begin
    rst = 1; clr_n = 1; we_n = 0; sel = 3'd5; din = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset", 8'h00);
    rst = 0; model = 8'h00;

    step(1, 0, 3'd1, 1); check("R6 sel1", 8'h02);
    step(1, 0, 3'd4, 1); check("R6 sel4", 8'h12);
    step(1, 0, 3'd7, 1); check("R5 update", 8'h92);
    step(1, 0, 3'd1, 0); check("R5 clear bit", 8'h90);
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 3'(i * 3), i[0]); check("R4 hold ignores sel/din", 8'h90);
    end
    step(0, 1, 3'd3, 1); check("R2 clear", 8'h00);

    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++)
        for (int d = 0; d < 2; d++) begin
          step(1, 0, 3'((a * 5 + 3) % 8), 1'(a % 2));
          step(1, 0, 3'((a * 3 + 1) % 8), 1);
          step(m[1], m[0], 3'(a), 1'(d));
          case (m)
            0: check("R3 decode", model);
            1: check("R2 clear all", model);
            2: check("R5 single update", model);
            default: check("R4 hold", model);
          endcase
        end

    for (int i = 0; i < 8; i++) step(1, 0, 3'(i), 1'(i % 3 == 0));
    step(1, 1, 3'd0, 0);
    check("R7 retained last writes", 8'h49);

    rst = 1; @(posedge clk); #1; check("R1 reset after run", 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog: timeout actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule